// File: doc/BRIEF.md
# DRAM Bank State Tracker

This block sits in the command path of a DDR memory controller. It follows every command sent to the four banks of a DRAM device and keeps a record of which banks have a row open. It runs per-bank counters for the minimum row-active time and the precharge recovery time, and judges each command at the moment it is issued. When a command would break the bank protocol, the block raises a one-cycle error that names the bank. The illegal command is then dropped and leaves every bank as it was.

A read or write may ask for an automatic precharge. The tracker then closes that bank without a further command. It does so once the burst has finished and the row has been open for long enough. The scheduler reads the per-bank open and ready flags to choose its next command. Refresh, the data path and the physical interface are handled elsewhere.

Top module: `bank_state_tracker`

## Requirements
- R1: After a synchronous reset, every bank reads idle (`bank_open` all zero) and ready (`bank_ready` all one), and `err_pulse` is low.
- R2: ACTIVATE (code 1) to a bank that is idle and ready sets its `bank_open` bit after the next clock edge. ACTIVATE to a bank that is open, or still inside its precharge time, is illegal.
- R3: READ (code 2) or WRITE (code 3) to a bank that is not open is illegal and leaves the bank closed. The same command is legal once an ACTIVATE has opened the bank.
- R4: PRECHARGE (code 4) with `cmd_a10` low closes only the bank on `cmd_bank`. That bank reads not ready for `T_RP` cycles counted from the precharge edge, and an ACTIVATE to it is legal again `T_RP` cycles after the precharge.
- R5: PRECHARGE with `cmd_a10` high closes every bank that is open, whatever is on `cmd_bank`. If any open bank may not yet be closed, the whole command is illegal, it reports the lowest such bank, and no bank closes.
- R6: PRECHARGE to a bank that is idle or already precharging raises no error and changes nothing. In particular it does not restart the precharge time.
- R7: An explicit PRECHARGE is illegal when it comes fewer than `T_RAS` cycles after the bank's ACTIVATE, or while a read or write burst on that bank is still in progress. The bank stays open.
- R8: READ or WRITE with `cmd_a10` high requests an automatic precharge. The bank reads not ready from that command on. It closes at the first edge that is at least `BURST_LEN` cycles after the command and at least `T_RAS` cycles after the ACTIVATE, and it becomes ready again once `T_RP` has elapsed. A READ or WRITE to the bank while the close is pending is illegal.
- R9: The automatic precharge request applies to a single command. A later READ with `cmd_a10` low leaves the bank open indefinitely.
- R10: BURST TERMINATE (code 5) cuts short the most recent READ that was issued without automatic precharge. The row stays open, and a PRECHARGE on the next cycle is legal when `T_RAS` has been met.
- R11: An illegal command produces `err_pulse` high for exactly the cycle after it, with `err_bank` equal to the bank at fault. The command changes no bank state and does not restart any counter. A cycle with no command never produces an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_code | input | 3 | Command code: 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 BURST TERMINATE |
| cmd_bank | input | 2 | Bank targeted by the command |
| cmd_a10 | input | 1 | Precharge-all on PRECHARGE, automatic precharge on READ/WRITE |
| bank_open | output | 4 | One bit per bank, set while a row is open |
| bank_ready | output | 4 | One bit per bank, clear while precharge recovery or a pending automatic close blocks the bank |
| err_pulse | output | 1 | One-cycle flag for an illegal command |
| err_bank | output | 2 | Bank at fault while `err_pulse` is high, zero otherwise |

## Verification
Commands are sent in close sequences that land one cycle before and one cycle after each timing boundary. This separates an off-by-one in the row-active counter or the recovery counter from correct behaviour. The automatic close is tried twice, once limited by the row-active time and once limited by the burst length, so that both sides of the "later of the two" rule are seen. Precharge is sent in single-bank and all-bank form, to idle banks and to banks already precharging, and as an all-bank command that one young bank blocks. Together these show the bank selection, the no-op cases and the all-or-nothing rule. A burst truncation followed at once by a precharge tells a truncated burst apart from one that is still running.

// File: rtl/bst_pkg.sv
// Package: shared command and bank-state encodings for the bank state tracker.
// Assumes a 3-bit command code field on the controller side.
package bst_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_BST = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE  = 2'd0,
        BK_OPEN  = 2'd1,
        BK_PRECH = 2'd2
    } bank_state_e;

endpackage

// File: rtl/bst_bank_ctrl.sv
// Module: bst_bank_ctrl
// One bank's state machine and its timing counters. It counts the cycles since
// ACTIVATE (saturating at T_RAS), the cycles left in the current burst and the
// precharge recovery time. It starts an automatic precharge when one is pending,
// the burst is over and T_RAS is met.
// Assumes: strobes come from the command checker, which lets only legal
// commands through and asserts at most one strobe per cycle. T_RAS, T_RP and
// BURST_LEN are all at least 1.
module bst_bank_ctrl
    import bst_pkg::*;
#(
    parameter int T_RAS     = 5,
    parameter int T_RP      = 3,
    parameter int BURST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_go,
    input  logic rdwr_go,
    input  logic rdwr_ap,
    input  logic pre_go,
    input  logic bst_go,
    output logic is_open,
    output logic is_ready,
    output logic can_act,
    output logic ras_met,
    output logic burst_busy,
    output logic ap_pend
);
    localparam int RAS_W = $clog2(T_RAS + 1);
    localparam int RP_W  = $clog2(T_RP + 1);
    localparam int BL_W  = $clog2(BURST_LEN + 1);
    localparam logic [RAS_W-1:0] RAS_MAX  = RAS_W'(T_RAS);
    localparam logic [RP_W-1:0]  RP_LOAD  = RP_W'(T_RP);
    localparam logic [BL_W-1:0]  BL_LOAD  = BL_W'(BURST_LEN - 1);

    bank_state_e      state;
    logic [RAS_W-1:0] ras_cnt;
    logic [RP_W-1:0]  rp_cnt;
    logic [BL_W-1:0]  burst_cnt;
    logic             rp_last;
    logic             auto_fire;

    // Derive the status flags the checker and the ports need from the state.
    always_comb begin
        rp_last    = (state == BK_PRECH) && (rp_cnt == RP_W'(1));
        ras_met    = (ras_cnt == RAS_MAX);
        burst_busy = (burst_cnt != '0);
        is_open    = (state == BK_OPEN);
        can_act    = (state == BK_IDLE) || rp_last;
        is_ready   = !((state == BK_PRECH) && !rp_last) && !ap_pend;
        auto_fire  = ap_pend && !burst_busy && ras_met;
    end

    // Advance the bank state and all per-bank counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= BK_IDLE;
            ras_cnt   <= '0;
            rp_cnt    <= '0;
            burst_cnt <= '0;
            ap_pend   <= 1'b0;
        end else if (act_go) begin
            state     <= BK_OPEN;
            ras_cnt   <= RAS_W'(1);
            burst_cnt <= '0;
            ap_pend   <= 1'b0;
        end else begin
            unique case (state)
                BK_OPEN: begin
                    if (!ras_met) begin
                        ras_cnt <= ras_cnt + RAS_W'(1);
                    end
                    if (burst_busy) begin
                        burst_cnt <= burst_cnt - BL_W'(1);
                    end
                    if (rdwr_go) begin
                        burst_cnt <= BL_LOAD;
                        ap_pend   <= rdwr_ap;
                    end
                    if (bst_go) begin
                        burst_cnt <= '0;
                    end
                    if (pre_go || auto_fire) begin
                        state   <= BK_PRECH;
                        rp_cnt  <= RP_LOAD;
                        ap_pend <= 1'b0;
                    end
                end
                BK_PRECH: begin
                    if (rp_cnt <= RP_W'(1)) begin
                        state <= BK_IDLE;
                    end else begin
                        rp_cnt <= rp_cnt - RP_W'(1);
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/bst_cmd_check.sv
// Module: bst_cmd_check
// Combinational legality check for one incoming command against the status of
// all banks. It turns a legal command into per-bank strobes. An illegal one
// gives a flag and the bank at fault. Precharge-all is all-or-nothing.
// Assumes: the status vectors come from registered bank state.
module bst_cmd_check
    import bst_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_code,
    input  logic [BANK_W-1:0]    cmd_bank,
    input  logic                 cmd_a10,
    input  logic [NUM_BANKS-1:0] is_open,
    input  logic [NUM_BANKS-1:0] is_ready,
    input  logic [NUM_BANKS-1:0] can_act,
    input  logic [NUM_BANKS-1:0] ras_met,
    input  logic [NUM_BANKS-1:0] burst_busy,
    input  logic [NUM_BANKS-1:0] ap_pend,
    input  logic                 trk_valid,
    input  logic [BANK_W-1:0]    trk_bank,
    output logic [NUM_BANKS-1:0] act_go,
    output logic [NUM_BANKS-1:0] rdwr_go,
    output logic [NUM_BANKS-1:0] pre_go,
    output logic [NUM_BANKS-1:0] bst_go,
    output logic                 illegal,
    output logic [BANK_W-1:0]    fault_bank
);
    logic [NUM_BANKS-1:0] closable;
    logic [NUM_BANKS-1:0] viol;
    logic [BANK_W-1:0]    first_viol;
    cmd_e                 cmd;

    // Find which banks a precharge may close now and which it may not.
    always_comb begin
        closable = is_open & ~ap_pend;
        viol     = closable & ~(ras_met & ~burst_busy);
    end

    // Pick the lowest-numbered bank that blocks a precharge-all.
    always_comb begin
        first_viol = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (viol[i]) begin
                first_viol = BANK_W'(i);
            end
        end
    end

    // Judge the command and raise the matching strobe or the fault.
    always_comb begin
        cmd        = cmd_e'(cmd_code);
        act_go     = '0;
        rdwr_go    = '0;
        pre_go     = '0;
        bst_go     = '0;
        illegal    = 1'b0;
        fault_bank = '0;
        if (cmd_valid) begin
            unique case (cmd)
                CMD_ACT: begin
                    if (can_act[cmd_bank]) begin
                        act_go[cmd_bank] = 1'b1;
                    end else begin
                        illegal    = 1'b1;
                        fault_bank = cmd_bank;
                    end
                end
                CMD_RD, CMD_WR: begin
                    if (is_open[cmd_bank] && is_ready[cmd_bank]) begin
                        rdwr_go[cmd_bank] = 1'b1;
                    end else begin
                        illegal    = 1'b1;
                        fault_bank = cmd_bank;
                    end
                end
                CMD_PRE: begin
                    if (cmd_a10) begin
                        if (|viol) begin
                            illegal    = 1'b1;
                            fault_bank = first_viol;
                        end else begin
                            pre_go = closable;
                        end
                    end else if (closable[cmd_bank]) begin
                        if (viol[cmd_bank]) begin
                            illegal    = 1'b1;
                            fault_bank = cmd_bank;
                        end else begin
                            pre_go[cmd_bank] = 1'b1;
                        end
                    end
                end
                CMD_BST: begin
                    if (trk_valid && burst_busy[trk_bank] && !ap_pend[trk_bank]) begin
                        bst_go[trk_bank] = 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/bst_read_tracker.sv
// Module: bst_read_tracker
// Remembers the bank of the latest READ issued without automatic precharge,
// which is the burst that BURST TERMINATE may cut short. The entry is dropped
// once it is used, or when a later command to that bank replaces the burst or
// the row.
// Assumes: strobes are the legal-command strobes from the checker.
module bst_read_tracker
    import bst_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           cmd_code,
    input  logic [BANK_W-1:0]    cmd_bank,
    input  logic                 cmd_a10,
    input  logic [NUM_BANKS-1:0] act_go,
    input  logic [NUM_BANKS-1:0] rdwr_go,
    input  logic [NUM_BANKS-1:0] pre_go,
    input  logic [NUM_BANKS-1:0] bst_go,
    output logic                 trk_valid,
    output logic [BANK_W-1:0]    trk_bank
);
    // Update the record of the truncatable READ.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_valid <= 1'b0;
            trk_bank  <= '0;
        end else if (|bst_go) begin
            trk_valid <= 1'b0;
        end else if (|rdwr_go) begin
            if ((cmd_code == CMD_RD) && !cmd_a10) begin
                trk_valid <= 1'b1;
                trk_bank  <= cmd_bank;
            end else if (cmd_bank == trk_bank) begin
                trk_valid <= 1'b0;
            end
        end else if (act_go[trk_bank] || pre_go[trk_bank]) begin
            trk_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/bank_state_tracker.sv
// Module: bank_state_tracker (top)
// Tracks open/idle/precharging state and timing for every bank of a DRAM
// device. It checks each issued command for legality and reports an illegal
// one as a one-cycle error with the bank index.
// Assumes: at most one command per cycle; timing parameters are in clock
// cycles and at least 1.
module bank_state_tracker
    import bst_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RAS     = 5,
    parameter int T_RP      = 3,
    parameter int BURST_LEN = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_code,
    input  logic [BANK_W-1:0]    cmd_bank,
    input  logic                 cmd_a10,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic [NUM_BANKS-1:0] bank_ready,
    output logic                 err_pulse,
    output logic [BANK_W-1:0]    err_bank
);
    logic [NUM_BANKS-1:0] can_act_vec;
    logic [NUM_BANKS-1:0] ras_met_vec;
    logic [NUM_BANKS-1:0] busy_vec;
    logic [NUM_BANKS-1:0] ap_pend_vec;
    logic [NUM_BANKS-1:0] act_go;
    logic [NUM_BANKS-1:0] rdwr_go;
    logic [NUM_BANKS-1:0] pre_go;
    logic [NUM_BANKS-1:0] bst_go;
    logic                 illegal;
    logic [BANK_W-1:0]    fault_bank;
    logic                 trk_valid;
    logic [BANK_W-1:0]    trk_bank;

    bst_cmd_check #(
        .NUM_BANKS (NUM_BANKS)
    ) check_i (
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .cmd_bank   (cmd_bank),
        .cmd_a10    (cmd_a10),
        .is_open    (bank_open),
        .is_ready   (bank_ready),
        .can_act    (can_act_vec),
        .ras_met    (ras_met_vec),
        .burst_busy (busy_vec),
        .ap_pend    (ap_pend_vec),
        .trk_valid  (trk_valid),
        .trk_bank   (trk_bank),
        .act_go     (act_go),
        .rdwr_go    (rdwr_go),
        .pre_go     (pre_go),
        .bst_go     (bst_go),
        .illegal    (illegal),
        .fault_bank (fault_bank)
    );

    bst_read_tracker #(
        .NUM_BANKS (NUM_BANKS)
    ) tracker_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_code  (cmd_code),
        .cmd_bank  (cmd_bank),
        .cmd_a10   (cmd_a10),
        .act_go    (act_go),
        .rdwr_go   (rdwr_go),
        .pre_go    (pre_go),
        .bst_go    (bst_go),
        .trk_valid (trk_valid),
        .trk_bank  (trk_bank)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bst_bank_ctrl #(
            .T_RAS     (T_RAS),
            .T_RP      (T_RP),
            .BURST_LEN (BURST_LEN)
        ) bank_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_go     (act_go[b]),
            .rdwr_go    (rdwr_go[b]),
            .rdwr_ap    (cmd_a10),
            .pre_go     (pre_go[b]),
            .bst_go     (bst_go[b]),
            .is_open    (bank_open[b]),
            .is_ready   (bank_ready[b]),
            .can_act    (can_act_vec[b]),
            .ras_met    (ras_met_vec[b]),
            .burst_busy (busy_vec[b]),
            .ap_pend    (ap_pend_vec[b])
        );
    end

    // Register the error report so that it lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pulse <= 1'b0;
            err_bank  <= '0;
        end else begin
            err_pulse <= illegal;
            err_bank  <= illegal ? fault_bank : '0;
        end
    end

endmodule

// File: rtl/bst_checker.sv
// Module: bst_checker
// Protocol properties of the bank state tracker, checked at its ports and on
// the pending-auto-precharge vector. It is bound into every instance of the top.
module bst_checker #(
    parameter int NUM_BANKS = 4,
    parameter int T_RP      = 3,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic [2:0]           cmd_code,
    input logic [BANK_W-1:0]    cmd_bank,
    input logic                 cmd_a10,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic [NUM_BANKS-1:0] bank_ready,
    input logic [NUM_BANKS-1:0] bank_ap,
    input logic                 err_pulse,
    input logic [BANK_W-1:0]    err_bank
);
    p_act_open_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd1 && bank_open[cmd_bank])
        |=> (err_pulse && err_bank == $past(cmd_bank)));

    p_rdwr_closed_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_code == 3'd2 || cmd_code == 3'd3) && !bank_open[cmd_bank])
        |=> (err_pulse && err_bank == $past(cmd_bank) && !bank_open[$past(cmd_bank)]));

    p_pre_all_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd4 && cmd_a10)
        |=> (err_pulse || ((bank_open & $past(bank_open & ~bank_ap)) == '0)));

    p_pre_idle_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd4 && !cmd_a10 && !bank_open[cmd_bank])
        |=> (!err_pulse && !bank_open[$past(cmd_bank)]));

    p_quiet_no_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !err_pulse);

    if (T_RP > 1) begin : g_rp
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
            p_closed_not_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(bank_open[b]) |-> !bank_ready[b]);
        end
    end

endmodule

bind bank_state_tracker bst_checker #(
    .NUM_BANKS (NUM_BANKS),
    .T_RP      (T_RP)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .cmd_bank   (cmd_bank),
    .cmd_a10    (cmd_a10),
    .bank_open  (bank_open),
    .bank_ready (bank_ready),
    .bank_ap    (ap_pend_vec),
    .err_pulse  (err_pulse),
    .err_bank   (err_bank)
);

// File: tb/bank_state_tracker_tb_top.sv
// Directed bench for bank_state_tracker with the default parameters
// (4 banks, T_RAS 5, T_RP 3, BURST_LEN 4). Inputs change and outputs are
// sampled on the falling clock edge.
module bank_state_tracker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] C_ACT = 3'd1;
    localparam logic [2:0] C_RD  = 3'd2;
    localparam logic [2:0] C_WR  = 3'd3;
    localparam logic [2:0] C_PRE = 3'd4;
    localparam logic [2:0] C_BST = 3'd5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic       cmd_a10 = 1'b0;
    logic [3:0] bank_open;
    logic [3:0] bank_ready;
    logic       err_pulse;
    logic [1:0] err_bank;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bank_state_tracker dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .cmd_bank   (cmd_bank),
        .cmd_a10    (cmd_a10),
        .bank_open  (bank_open),
        .bank_ready (bank_ready),
        .err_pulse  (err_pulse),
        .err_bank   (err_bank)
    );

    // Compare one observed value with its expected value and record the result.
    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Issue one command at the current falling edge; return one cycle later.
    task automatic issue(input logic [2:0] code, input logic [1:0] bank, input logic a10);
        cmd_valid = 1'b1;
        cmd_code  = code;
        cmd_bank  = bank;
        cmd_a10   = a10;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_code  = 3'd0;
        cmd_a10   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "open after reset", bank_open, 0);
        check("R1", "ready after reset", bank_ready, 15);
        check("R1", "err after reset", err_pulse, 0);
    endtask

    task automatic t_activate();
        do_reset();
        issue(C_ACT, 2'd0, 1'b0);
        check("R2", "open after ACT", bank_open, 1);
        check("R2", "err after legal ACT", err_pulse, 0);
        idle(2);
        issue(C_ACT, 2'd0, 1'b0);
        check("R2", "err on ACT to open bank", err_pulse, 1);
        check("R11", "err_bank on ACT to open bank", err_bank, 0);
        check("R11", "bank stays open", bank_open, 1);
        idle(1);
        check("R11", "err lasts one cycle", err_pulse, 0);
        issue(C_PRE, 2'd0, 1'b0);
        check("R11", "illegal ACT kept row-active count", err_pulse, 0);
        check("R11", "bank closed by PRE", bank_open, 0);
    endtask

    task automatic t_rw_idle();
        do_reset();
        issue(C_RD, 2'd3, 1'b0);
        check("R3", "err on READ to idle", err_pulse, 1);
        check("R3", "err_bank READ", err_bank, 3);
        check("R3", "idle bank stays closed", bank_open, 0);
        issue(C_WR, 2'd2, 1'b0);
        check("R3", "err on WRITE to idle", err_pulse, 1);
        check("R3", "err_bank WRITE", err_bank, 2);
        issue(C_ACT, 2'd2, 1'b0);
        issue(C_WR, 2'd2, 1'b0);
        check("R3", "WRITE to open bank legal", err_pulse, 0);
        check("R3", "bank 2 open", bank_open, 4);
    endtask

    task automatic t_pre_single();
        do_reset();
        issue(C_ACT, 2'd0, 1'b0);
        issue(C_ACT, 2'd1, 1'b0);
        idle(5);
        issue(C_PRE, 2'd1, 1'b0);
        check("R4", "only bank 1 closed", bank_open, 1);
        check("R4", "bank 1 not ready in tRP", bank_ready[1], 0);
        issue(C_PRE, 2'd1, 1'b0);
        check("R6", "PRE to precharging bank no err", err_pulse, 0);
        idle(1);
        check("R6", "tRP not restarted, ready", bank_ready[1], 1);
        issue(C_ACT, 2'd1, 1'b0);
        check("R4", "ACT after tRP legal", err_pulse, 0);
        check("R4", "bank 1 reopened", bank_open, 3);
        issue(C_PRE, 2'd3, 1'b0);
        check("R6", "PRE to idle bank no err", err_pulse, 0);
        check("R6", "PRE to idle bank no change", bank_open, 3);
        issue(C_PRE, 2'd0, 1'b0);
        issue(C_ACT, 2'd0, 1'b0);
        check("R2", "ACT inside tRP illegal", err_pulse, 1);
        check("R2", "err_bank ACT inside tRP", err_bank, 0);
    endtask

    task automatic t_pre_all();
        do_reset();
        issue(C_ACT, 2'd1, 1'b0);
        issue(C_ACT, 2'd3, 1'b0);
        issue(C_PRE, 2'd0, 1'b1);
        check("R5", "PRE-all blocked by tRAS", err_pulse, 1);
        check("R5", "lowest blocking bank", err_bank, 1);
        check("R5", "no bank closed", bank_open, 10);
        idle(5);
        issue(C_PRE, 2'd2, 1'b1);
        check("R5", "PRE-all legal", err_pulse, 0);
        check("R5", "all banks closed", bank_open, 0);
    endtask

    task automatic t_ras();
        do_reset();
        issue(C_ACT, 2'd2, 1'b0);
        idle(3);
        issue(C_PRE, 2'd2, 1'b0);
        check("R7", "PRE before tRAS illegal", err_pulse, 1);
        check("R7", "err_bank tRAS", err_bank, 2);
        check("R7", "bank stays open", bank_open, 4);
        issue(C_PRE, 2'd2, 1'b0);
        check("R7", "PRE at tRAS legal", err_pulse, 0);
        check("R7", "bank closed at tRAS", bank_open, 0);
    endtask

    task automatic t_auto_pre();
        do_reset();
        issue(C_ACT, 2'd1, 1'b0);
        issue(C_RD, 2'd1, 1'b1);
        check("R8", "open after auto READ", bank_open, 2);
        check("R8", "not ready with close pending", bank_ready[1], 0);
        issue(C_RD, 2'd1, 1'b0);
        check("R8", "READ while close pending illegal", err_pulse, 1);
        idle(2);
        check("R8", "still open before tRAS", bank_open, 2);
        idle(1);
        check("R8", "closed at tRAS", bank_open, 0);
        idle(1);
        check("R8", "not ready inside tRP", bank_ready[1], 0);
        idle(1);
        check("R8", "ready after tRP", bank_ready[1], 1);
        do_reset();
        issue(C_ACT, 2'd0, 1'b0);
        idle(6);
        issue(C_WR, 2'd0, 1'b1);
        idle(3);
        check("R8", "open until burst ends", bank_open, 1);
        idle(1);
        check("R8", "closed at burst end", bank_open, 0);
    endtask

    task automatic t_auto_once();
        do_reset();
        issue(C_ACT, 2'd3, 1'b0);
        idle(5);
        issue(C_RD, 2'd3, 1'b1);
        idle(8);
        check("R9", "auto close happened", bank_open, 0);
        issue(C_ACT, 2'd3, 1'b0);
        idle(5);
        issue(C_RD, 2'd3, 1'b0);
        idle(10);
        check("R9", "plain READ keeps row open", bank_open, 8);
        check("R9", "plain READ bank ready", bank_ready[3], 1);
    endtask

    task automatic t_burst_term();
        do_reset();
        issue(C_ACT, 2'd0, 1'b0);
        idle(5);
        issue(C_RD, 2'd0, 1'b0);
        issue(C_PRE, 2'd0, 1'b0);
        check("R7", "PRE during burst illegal", err_pulse, 1);
        check("R7", "open after burst PRE", bank_open, 1);
        issue(C_RD, 2'd0, 1'b0);
        issue(C_BST, 2'd2, 1'b0);
        check("R10", "BST no err", err_pulse, 0);
        check("R10", "row stays open", bank_open, 1);
        issue(C_PRE, 2'd0, 1'b0);
        check("R10", "PRE after BST legal", err_pulse, 0);
        check("R10", "closed after BST and PRE", bank_open, 0);
    endtask

    bit done = 1'b0;

    initial begin
        idle(1);
        t_reset();
        t_activate();
        t_rw_idle();
        t_pre_single();
        t_pre_all();
        t_ras();
        t_auto_pre();
        t_auto_once();
        t_burst_term();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule